// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block holds three independent down-counting timers behind one register interface. Each channel has a reload constant, a live counter and a control word. A shared start word holds one run bit per channel. A running channel decrements once per tick. When it would pass below zero it takes the reload constant instead and sets a sticky underflow flag. Together with a per-channel enable, that flag drives the channel's interrupt line.

The tick for each channel comes from one of three places, picked by the control word: a private prescaler on the peripheral clock (the `clk` input), a real-time-clock tick input, or an external tick input. The prescaler restarts from phase zero each time its channel starts, so the first decrement comes exactly one prescale period after the start write. Writes take effect on the rising clock edge while `bus_wr` is high. Reads are combinational from `bus_addr`, so software always sees the live count.

Top module: `tmr3_unit`

## Requirements
- R1: After reset every reload constant and every counter reads 0xFFFFFFFF, every control word reads 0, the start word reads 0 and every `irq_out` bit is 0.
- R2: The start word is at byte address 0x00, and its bit n runs channel n. Channel n's reload constant, counter and control word are at 0x04+12n, 0x08+12n and 0x0C+12n. A write to one channel's register leaves the other channels' registers unchanged.
- R3: Control bits [2:0] with value c in 0..4 make the channel decrement once every 4^(c+1) clock cycles. The first decrement lands on the 4^(c+1)-th rising edge after the start write edge.
- R4: Control bits [2:0] = 5 is illegal. It drives `illegal_sel[n]` high, and the channel decrements once every 4096 cycles. Any other code keeps `illegal_sel[n]` low.
- R5: Control bits [2:0] = 6 takes one tick per cycle in which `rtc_tick` is high. Code 7 does the same with `ext_tick`. The input that is not selected has no effect on the count.
- R6: A tick while the counter is 0 loads the reload constant and sets the underflow flag (control bit 8). With a constant of 0, every tick leaves the counter at 0 and sets the flag.
- R7: A control write stores bit 9 (input-capture flag) and bit 5 (interrupt enable). Writing bit 8 as 0 clears the underflow flag. Writing bit 8 as 1 never sets it.
- R8: `irq_out[n]` is high exactly when channel n's underflow flag and interrupt enable are both 1. It rises right after an enable write while the flag is set, or after an underflow while enabled, and it drops when either bit is cleared.
- R9: A stopped channel holds its count. A counter read returns the value current at that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW (6) | Byte address of the register |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Combinational read data for `bus_addr` |
| rtc_tick | input | 1 | Real-time-clock tick, one pulse per cycle high |
| ext_tick | input | 1 | External tick, one pulse per cycle high |
| irq_out | output | NCH (3) | Per-channel underflow interrupt |
| illegal_sel | output | NCH (3) | High while a channel selects the illegal source code |

## Verification
The prescaled path is exercised with every divider code from the start edge. The count is sampled one edge before and on the edge where the first decrement is due, which tells a correct divide ratio from an off-by-one phase. The tick-input path is driven with random reload constants, random start counts and random pulse trains on the selected input, with noise on the unselected one. The bench checks the counter and flag against a bench model, which separates correct wrap and reload behaviour from a stuck or double-counting one. Directed sequences cover the flag write rules, the interrupt rise and fall on each cause, a zero constant and a frozen stopped count.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
   localparam int BIT_ICF  = 9;
   localparam int BIT_UF   = 8;
   localparam int BIT_IE   = 5;
   localparam int STRIDE   = 12;
   localparam int CH_BASE  = 4;

   typedef enum logic [2:0] {
      SRC_D4 = 3'd0, SRC_D16 = 3'd1, SRC_D64 = 3'd2, SRC_D256 = 3'd3,
      SRC_D1K = 3'd4, SRC_BAD = 3'd5, SRC_RTC = 3'd6, SRC_EXT = 3'd7
   } src_e;

   // last prescaler phase for a divided source
   function automatic logic [11:0] presc_last(input logic [2:0] sel);
      logic [12:0] d;
      if (sel == SRC_BAD) d = 13'd4096;
      else                d = 13'd4 << (2 * sel);
      return 12'(d - 13'd1);
   endfunction
endpackage

// File: rtl/tmr3_prescale.sv
module tmr3_prescale #(
   parameter int PS_W = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] sel,
   input  logic       rtc_tick,
   input  logic       ext_tick,
   output logic       tick
);
   import tmr3_pkg::*;

   logic [PS_W-1:0] phase_q;
   logic [PS_W-1:0] last;
   logic            divided;
   logic            wrap;

   assign last    = PS_W'(presc_last(sel));
   assign divided = (sel != SRC_RTC) && (sel != SRC_EXT);
   assign wrap    = phase_q >= last;

   always_ff @(posedge clk) begin
      if (!rst_n || !run || !divided) phase_q <= '0;
      else if (wrap)                  phase_q <= '0;
      else                            phase_q <= phase_q + 1'b1;
   end

   always_comb begin
      unique case (sel)
         SRC_RTC: tick = run && rtc_tick;
         SRC_EXT: tick = run && ext_tick;
         default: tick = run && wrap;
      endcase
   end
endmodule

// File: rtl/tmr3_channel.sv
module tmr3_channel #(
   parameter int CW   = 32,
   parameter int PS_W = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          wr_const,
   input  logic          wr_cnt,
   input  logic          wr_ctrl,
   input  logic [CW-1:0] wdata,
   input  logic          rtc_tick,
   input  logic          ext_tick,
   output logic [CW-1:0] const_q,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] ctrl_rd,
   output logic          flag_q,
   output logic          ie_q,
   output logic          uf,
   output logic          irq,
   output logic          illegal
);
   import tmr3_pkg::*;

   logic [2:0] sel_q;
   logic       icf_q;
   logic       tick;

   tmr3_prescale #(.PS_W(PS_W)) u_ps (
      .clk(clk), .rst_n(rst_n), .run(run), .sel(sel_q),
      .rtc_tick(rtc_tick), .ext_tick(ext_tick), .tick(tick)
   );

   assign uf = tick && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         const_q <= '1;
         cnt_q   <= '1;
      end else begin
         if (wr_const) const_q <= wdata;
         if (wr_cnt)   cnt_q   <= wdata;
         else if (uf)  cnt_q   <= const_q;
         else if (tick) cnt_q  <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= SRC_D4;
         icf_q  <= 1'b0;
         ie_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            sel_q <= wdata[2:0];
            icf_q <= wdata[BIT_ICF];
            ie_q  <= wdata[BIT_IE];
         end
         if (uf)           flag_q <= 1'b1;
         else if (wr_ctrl) flag_q <= flag_q && wdata[BIT_UF];
      end
   end

   always_comb begin
      ctrl_rd          = '0;
      ctrl_rd[2:0]     = sel_q;
      ctrl_rd[BIT_IE]  = ie_q;
      ctrl_rd[BIT_UF]  = flag_q;
      ctrl_rd[BIT_ICF] = icf_q;
   end

   assign irq     = flag_q && ie_q;
   assign illegal = (sel_q == SRC_BAD);
endmodule

// File: rtl/tmr3_unit.sv
module tmr3_unit #(
   parameter int NCH  = 3,
   parameter int CW   = 32,
   parameter int AW   = 6,
   parameter int PS_W = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_wr,
   input  logic [AW-1:0]  bus_addr,
   input  logic [CW-1:0]  bus_wdata,
   output logic [CW-1:0]  bus_rdata,
   input  logic           rtc_tick,
   input  logic           ext_tick,
   output logic [NCH-1:0] irq_out,
   output logic [NCH-1:0] illegal_sel
);
   import tmr3_pkg::*;

   localparam int TOP_ADDR = CH_BASE + STRIDE * NCH;

   if (TOP_ADDR > (1 << AW)) begin : g_bad_aw
      $error("address width too small for channel count");
   end
   if (CW < 10 || CW < NCH) begin : g_bad_cw
      $error("data width too small for control word");
   end
   if (PS_W < 12) begin : g_bad_ps
      $error("prescaler width must hold 4096 phases");
   end

   logic [NCH-1:0] run_q;
   logic [NCH-1:0] flag_v, ie_v, uf_v, cnt_wr_v;
   logic [CW-1:0]  const_v [NCH];
   logic [CW-1:0]  cnt_v   [NCH];
   logic [CW-1:0]  ctrl_v  [NCH];

   always_ff @(posedge clk) begin
      if (!rst_n)                           run_q <= '0;
      else if (bus_wr && bus_addr == '0)    run_q <= bus_wdata[NCH-1:0];
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int BASE = CH_BASE + STRIDE * i;
      logic wc, wn, wt;
      assign wc = bus_wr && (bus_addr == AW'(BASE));
      assign wn = bus_wr && (bus_addr == AW'(BASE + 4));
      assign wt = bus_wr && (bus_addr == AW'(BASE + 8));
      assign cnt_wr_v[i] = wn;

      tmr3_channel #(.CW(CW), .PS_W(PS_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .run(run_q[i]),
         .wr_const(wc), .wr_cnt(wn), .wr_ctrl(wt), .wdata(bus_wdata),
         .rtc_tick(rtc_tick), .ext_tick(ext_tick),
         .const_q(const_v[i]), .cnt_q(cnt_v[i]), .ctrl_rd(ctrl_v[i]),
         .flag_q(flag_v[i]), .ie_q(ie_v[i]), .uf(uf_v[i]),
         .irq(irq_out[i]), .illegal(illegal_sel[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) bus_rdata = CW'(run_q);
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == AW'(CH_BASE + STRIDE * i))     bus_rdata = const_v[i];
         if (bus_addr == AW'(CH_BASE + STRIDE * i + 4)) bus_rdata = cnt_v[i];
         if (bus_addr == AW'(CH_BASE + STRIDE * i + 8)) bus_rdata = ctrl_v[i];
      end
   end
endmodule

// File: rtl/tmr3_unit_chk.sv
module tmr3_unit_chk #(
   parameter int NCH = 3,
   parameter int CW  = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] run_q,
   input logic [NCH-1:0] flag_v,
   input logic [NCH-1:0] ie_v,
   input logic [NCH-1:0] uf_v,
   input logic [NCH-1:0] cnt_wr_v,
   input logic [NCH-1:0] irq_out,
   input logic [CW-1:0]  cnt_v   [NCH],
   input logic [CW-1:0]  const_v [NCH]
);
   for (genvar i = 0; i < NCH; i++) begin : g_a
      a_r7_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag_v[i] && !uf_v[i]) |=> !flag_v[i]);
      a_r6_flag_on_uf: assert property (@(posedge clk) disable iff (!rst_n)
         uf_v[i] |=> flag_v[i]);
      a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
         (uf_v[i] && !cnt_wr_v[i]) |=> cnt_v[i] == $past(const_v[i]));
      a_r9_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_q[i] && !cnt_wr_v[i]) |=> $stable(cnt_v[i]));
      a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[i] |-> (ie_v[i] && flag_v[i]));
   end
endmodule

bind tmr3_unit tmr3_unit_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_q(run_q), .flag_v(flag_v), .ie_v(ie_v),
   .uf_v(uf_v), .cnt_wr_v(cnt_wr_v), .irq_out(irq_out),
   .cnt_v(cnt_v), .const_v(const_v)
);

// File: tb/tmr3_unit_test.sv
module tmr3_unit_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_wr = 0;
   logic [5:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;
   logic        rtc_tick = 0, ext_tick = 0;
   logic [2:0]  irq_out, illegal_sel;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tmr3_unit uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_tick(rtc_tick),
      .ext_tick(ext_tick), .irq_out(irq_out), .illegal_sel(illegal_sel)
   );

   function automatic [5:0] a_const(int ch); return 6'(4 + 12 * ch); endfunction
   function automatic [5:0] a_cnt(int ch);   return 6'(8 + 12 * ch); endfunction
   function automatic [5:0] a_ctrl(int ch);  return 6'(12 + 12 * ch); endfunction
   function automatic int div_of(int code);
      return (code == 5) ? 4096 : (4 << (2 * code));
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic pulse(bit use_rtc, bit noise);
      @(negedge clk);
      rtc_tick = use_rtc ? 1'b1 : noise;
      ext_tick = use_rtc ? noise : 1'b1;
      @(negedge clk); rtc_tick = 0; ext_tick = 0;
   endtask

   // reference down-counter with reload
   task automatic model(int c0, int cst, int n, output int c, output bit f);
      c = c0; f = 0;
      for (int k = 0; k < n; k++) begin
         if (c == 0) begin c = cst; f = 1; end
         else c = c - 1;
      end
   endtask

   task automatic prescale_run(int ch, int code, string req);
      logic [31:0] d;
      wr(a_ctrl(ch), 32'(code));
      wr(a_cnt(ch), 32'd5);
      wr(6'h00, 32'(1 << ch));
      repeat (div_of(code) - 1) @(posedge clk);
      #1; rd(a_cnt(ch), d); chk(req, d, 32'd5);
      @(posedge clk); #1; rd(a_cnt(ch), d); chk(req, d, 32'd4);
      chk(req, 32'(illegal_sel[ch]), 32'(code == 5));
      wr(6'h00, 32'd0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int c, n, c0, cst;
      bit f, use_rtc;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1 reset state
      for (int ch = 0; ch < 3; ch++) begin
         rd(a_const(ch), d); chk("R1", d, 32'hFFFFFFFF);
         rd(a_cnt(ch), d);   chk("R1", d, 32'hFFFFFFFF);
         rd(a_ctrl(ch), d);  chk("R1", d, 32'h0);
      end
      rd(6'h00, d); chk("R1", d, 0);
      chk("R1", 32'(irq_out), 0);

      // R2 addressing and channel isolation
      wr(a_const(1), 32'h55);
      wr(a_cnt(2), 32'h77);
      rd(a_const(1), d); chk("R2", d, 32'h55);
      rd(a_cnt(2), d);   chk("R2", d, 32'h77);
      rd(a_cnt(1), d);   chk("R2", d, 32'hFFFFFFFF);
      rd(a_const(2), d); chk("R2", d, 32'hFFFFFFFF);
      wr(6'h00, 32'h5);
      rd(6'h00, d); chk("R2", d, 32'h5);
      wr(6'h00, 32'h0);

      // R3 and R9: divide by 16, first tick on 16th edge, live read, stop holds
      wr(a_ctrl(0), 32'd1);
      wr(a_cnt(0), 32'd100);
      wr(6'h00, 32'h1);
      repeat (15) @(posedge clk);
      #1; rd(a_cnt(0), d); chk("R3", d, 32'd100);
      @(posedge clk); #1; rd(a_cnt(0), d); chk("R9 live", d, 32'd99);
      wr(6'h00, 32'h0);
      repeat (100) @(posedge clk);
      #1; rd(a_cnt(0), d); chk("R9 stop", d, 32'd99);

      // R3 every legal divider, R4 illegal code
      for (int code = 0; code < 5; code++) prescale_run(1, code, "R3");
      prescale_run(1, 5, "R4");
      wr(a_ctrl(1), 32'd6);
      chk("R4", 32'(illegal_sel[1]), 0);

      // R5 and R6 random tick-input runs on channel 2
      for (int it = 0; it < 24; it++) begin
         cst = $urandom_range(0, 12);
         c0  = $urandom_range(0, 12);
         n   = $urandom_range(0, 30);
         use_rtc = $urandom_range(0, 1);
         wr(a_const(2), 32'(cst));
         wr(a_cnt(2), 32'(c0));
         wr(a_ctrl(2), use_rtc ? 32'd6 : 32'd7);
         wr(6'h00, 32'h4);
         for (int k = 0; k < n; k++) pulse(use_rtc, 1'($urandom_range(0, 1)));
         wr(6'h00, 32'h0);
         model(c0, cst, n, c, f);
         rd(a_cnt(2), d);  chk("R5 count", d, 32'(c));
         rd(a_ctrl(2), d); chk("R6 flag", 32'(d[8]), 32'(f));
      end

      // R6 zero constant
      wr(a_const(1), 0); wr(a_cnt(1), 0); wr(a_ctrl(1), 32'd7);
      wr(6'h00, 32'h2);
      repeat (3) pulse(0, 0);
      rd(a_cnt(1), d);  chk("R6 zero", d, 0);
      rd(a_ctrl(1), d); chk("R6 zero", 32'(d[8]), 1);
      pulse(1, 0);
      rd(a_cnt(1), d);  chk("R5 unselected", d, 0);
      wr(6'h00, 32'h0);

      // R7 and R8 flag rules and interrupt
      wr(a_const(2), 32'd3); wr(a_cnt(2), 0); wr(a_ctrl(2), 32'h007);
      wr(6'h00, 32'h4);
      pulse(0, 0);
      rd(a_cnt(2), d); chk("R6 reload", d, 32'd3);
      chk("R8", 32'(irq_out[2]), 0);
      wr(a_ctrl(2), 32'h127);
      chk("R8 enable", 32'(irq_out[2]), 1);
      wr(a_ctrl(2), 32'h027);
      chk("R7 clear", 32'(irq_out[2]), 0);
      wr(a_ctrl(2), 32'h127);
      rd(a_ctrl(2), d); chk("R7 no set", d, 32'h027);
      chk("R8", 32'(irq_out[2]), 0);
      repeat (4) pulse(0, 0);
      chk("R8 underflow", 32'(irq_out[2]), 1);
      wr(a_ctrl(2), 32'h107);
      chk("R8 disable", 32'(irq_out[2]), 0);
      wr(a_ctrl(2), 32'h307);
      rd(a_ctrl(2), d); chk("R7 icf", d, 32'h307);
      wr(6'h00, 32'h0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule